// File: doc/BRIEF.md
# SMM Memory Control Register with Lock

This block holds the 8-bit control byte that governs access to system-management memory, and decodes from that byte how each memory access is routed. Software writes the byte through a byte-write port and reads it back unchanged through a read port. Three request flags drive the routing port: whether the processor is in system-management mode, whether the access is an instruction fetch or a data reference, and whether the address lies inside the protected window. For each request the block raises either the DRAM output or the PCI output.

The stored byte never holds arbitrary values. The reserved top bit always reads as zero, and the low three bits always read as the fixed segment code. A lock bit, once stored, can only be cleared by reset. While it is set, it keeps the open bit cleared. One setting is illegal: open and closed both set while the register is enabled and unlocked. The block reports this setting on a level output and routes nothing while it lasts. A parameter selects whether the routing outputs are combinational or pass through one register stage.

Top module: `smram_ctl`

## Requirements
- R1: After reset the register reads 0x02. The byte layout is: bit 6 open, bit 5 closed, bit 4 lock, bit 3 enable, bits 2:0 segment code, bit 7 reserved.
- R2: A write stores bits 6:3 of the written byte. Bit 7 is forced to 0 and bits 2:0 are forced to 010. The stored value is readable on the cycle after the write edge.
- R3: Once lock (bit 4) is stored, every later write stores open = 0 and lock = 1, whatever the written byte holds. Only reset clears lock. The write that first sets lock keeps its own open bit.
- R4: With enable (bit 3) clear, every in-window access goes to PCI.
- R5: With enable set, lock clear, open set and closed clear, both fetches and data references go to DRAM, whether or not the processor is in SMM mode.
- R6: Outside SMM mode, when open is not in effect (open clear or lock set), accesses go to PCI.
- R7: In SMM mode with enable set and closed clear, both fetches and data references go to DRAM.
- R8: In SMM mode with enable set and closed set (and the setting legal), fetches go to DRAM and data references go to PCI.
- R9: The illegal output is high exactly while enable is set, lock is clear, and open and closed are both set. While it is high, both routing outputs are low.
- R10: With the in-window flag low, both routing outputs are low.
- R11: DRAM and PCI outputs are never high together. With the default configuration, the routing outputs follow the request flags in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Stored register value |
| smm_mode | input | 1 | Request is made in SMM mode |
| is_code | input | 1 | Request is an instruction fetch (1) or data reference (0) |
| in_window | input | 1 | Request address lies in the protected window |
| to_dram | output | 1 | Route request to DRAM |
| to_pci | output | 1 | Route request to PCI |
| illegal | output | 1 | Illegal open+closed setting is active |

## Verification
A write takes effect at the clock edge on which the strobe is sampled, so the bench reads `rd_data` at the following falling edge. In the default configuration the routing outputs are combinational in both the register and the request flags. The bench therefore applies each flag combination at a falling edge and samples two time units later, before the next rising edge. If the registered variant is chosen, the bench first waits one rising edge before sampling. For each of the 256 possible written bytes, the bench checks the read-back and all eight flag combinations against an arithmetic model. It repeats this sweep on a locked register, and finally resets to confirm that the lock clears.

// File: rtl/smram_pkg.sv
package smram_pkg;
   localparam int OPEN_B  = 6;
   localparam int CLOSE_B = 5;
   localparam int LOCK_B  = 4;
   localparam int EN_B    = 3;

   typedef struct packed {
      logic dram;
      logic pci;
      logic bad;
   } route_t;
endpackage

// File: rtl/smram_reg.sv
module smram_reg
   import smram_pkg::*;
#(
   parameter int              REG_W    = 8,
   parameter int              SEG_W    = 3,
   parameter logic [SEG_W-1:0] SEG_CODE = 3'b010
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] q
);
   localparam logic [REG_W-1:0] RST_VAL  = REG_W'(SEG_CODE);
   localparam logic [REG_W-1:0] KEEP_MSK = REG_W'(8'h78);

   logic [REG_W-1:0] nxt;

   always_comb begin
      nxt = (wr_data & KEEP_MSK) | RST_VAL;
      if (q[LOCK_B]) begin
         nxt[OPEN_B] = 1'b0;
         nxt[LOCK_B] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RST_VAL;
      else if (wr_en) q <= nxt;
   end
endmodule

// File: rtl/smram_route.sv
module smram_route
   import smram_pkg::*;
(
   input  logic   en,
   input  logic   open,
   input  logic   closed,
   input  logic   lock,
   input  logic   smm,
   input  logic   code,
   input  logic   win,
   output route_t rt
);
   logic bad, open_eff, go_dram;

   always_comb begin
      bad      = en & ~lock & open & closed;
      open_eff = open & ~lock;
      if (open_eff)   go_dram = 1'b1;
      else if (smm)   go_dram = ~closed | code;
      else            go_dram = 1'b0;
      rt.bad  = bad;
      rt.dram = win & en & ~bad & go_dram;
      rt.pci  = win & ~bad & (~en | ~go_dram);
   end
endmodule

// File: rtl/smram_out_stage.sv
module smram_out_stage
   import smram_pkg::*;
#(
   parameter bit REGISTERED = 1'b0
) (
   input  logic   clk,
   input  logic   rst_n,
   input  route_t d,
   output route_t q
);
   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/smram_ctl.sv
module smram_ctl
   import smram_pkg::*;
#(
   parameter int               REG_W     = 8,
   parameter int               SEG_W     = 3,
   parameter logic [SEG_W-1:0] SEG_CODE  = 3'b010,
   parameter bit               ROUTE_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             smm_mode,
   input  logic             is_code,
   input  logic             in_window,
   output logic             to_dram,
   output logic             to_pci,
   output logic             illegal
);
   generate
      if (REG_W != 8) begin : g_bad_w
         $error("smram_ctl: REG_W must be 8");
      end
      if (SEG_W + 5 != REG_W) begin : g_bad_seg
         $error("smram_ctl: SEG_W must leave five control bits");
      end
   endgenerate

   logic [REG_W-1:0] ctrl;
   route_t           rt_d, rt_q;

   smram_reg #(.REG_W(REG_W), .SEG_W(SEG_W), .SEG_CODE(SEG_CODE)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .q(ctrl)
   );

   smram_route u_route (
      .en(ctrl[EN_B]), .open(ctrl[OPEN_B]), .closed(ctrl[CLOSE_B]),
      .lock(ctrl[LOCK_B]), .smm(smm_mode), .code(is_code),
      .win(in_window), .rt(rt_d)
   );

   smram_out_stage #(.REGISTERED(ROUTE_REG)) u_out (
      .clk(clk), .rst_n(rst_n), .d(rt_d), .q(rt_q)
   );

   assign rd_data = ctrl;
   assign to_dram = rt_q.dram;
   assign to_pci  = rt_q.pci;
   assign illegal = rt_q.bad;
endmodule

// File: rtl/smram_ctl_chk.sv
module smram_ctl_chk #(
   parameter bit LAT = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] rd_data,
   input logic       in_window,
   input logic       to_dram,
   input logic       to_pci,
   input logic       illegal
);
   // R2
   fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data[7] == 1'b0 && rd_data[2:0] == 3'b010));

   // R3
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[4] |=> rd_data[4]);

   // R3
   lock_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[4] && wr_en) |=> !rd_data[6]);

   // R9
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!to_dram && !to_pci));

   // R11
   one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(to_dram && to_pci));

   generate
      if (LAT) begin : g_lat1
         // R10
         no_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_window |=> (!to_dram && !to_pci));
         // R4
         disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_data[3] |=> !to_dram);
      end else begin : g_lat0
         // R10
         no_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_window |-> (!to_dram && !to_pci));
         // R4
         disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_data[3] |-> !to_dram);
      end
   endgenerate
endmodule

bind smram_ctl smram_ctl_chk #(.LAT(ROUTE_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data),
   .in_window(in_window), .to_dram(to_dram), .to_pci(to_pci),
   .illegal(illegal)
);

// File: tb/smram_ctl_bench.sv
module smram_ctl_bench;
   localparam bit ROUTE_REG = 1'b0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       smm_mode = 1'b0, is_code = 1'b0, in_window = 1'b0;
   logic       to_dram, to_pci, illegal;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   smram_ctl #(.ROUTE_REG(ROUTE_REG)) u_smram_ctl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .smm_mode(smm_mode), .is_code(is_code),
      .in_window(in_window), .to_dram(to_dram), .to_pci(to_pci),
      .illegal(illegal)
   );

   function automatic logic [7:0] m_write(logic [7:0] cur, logic [7:0] wd);
      logic [7:0] n;
      n = (wd & 8'h78) | 8'h02;
      if (cur[4]) begin n[6] = 1'b0; n[4] = 1'b1; end
      return n;
   endfunction

   // returns {dram, pci, illegal}
   function automatic logic [2:0] m_route(logic [7:0] r, logic s, logic c, logic w);
      logic en, op, cl, lk, bad, d, p;
      en = r[3]; op = r[6]; cl = r[5]; lk = r[4];
      bad = en && !lk && op && cl;
      d = 1'b0; p = 1'b0;
      if (w && !bad) begin
         if (!en)            p = 1'b1;        // R4
         else if (op && !lk) d = 1'b1;        // R5
         else if (!s)        p = 1'b1;        // R6
         else if (!cl)       d = 1'b1;        // R7
         else if (c)         d = 1'b1;        // R8
         else                p = 1'b1;
      end
      return {d, p, bad};
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic do_write(logic [7:0] v);
      @(negedge clk); wr_en = 1'b1; wr_data = v;
      @(posedge clk); #1 wr_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic sweep_route(logic [7:0] r, string tag);
      for (int k = 0; k < 8; k++) begin
         logic [2:0] e;
         @(negedge clk);
         smm_mode = k[0]; is_code = k[1]; in_window = k[2];
         e = m_route(r, k[0], k[1], k[2]);
         if (ROUTE_REG) @(posedge clk);
         #2;
         check({tag, " route"}, {5'b0, to_dram, to_pci, illegal}, {5'b0, e});
      end
   endtask

   initial begin
      logic [7:0] exp;
      do_reset();
      // R1 reset value
      check("R1", rd_data, 8'h02);
      sweep_route(8'h02, "R1");
      // R2 R4..R11 over every written byte from reset
      for (int v = 0; v < 256; v++) begin
         do_reset();
         do_write(v[7:0]);
         exp = m_write(8'h02, v[7:0]);
         check("R2", rd_data, exp);
         sweep_route(exp, "R4-R11");
         // write again: lock from first write must stick (R3)
         do_write(8'h00);
         exp = m_write(exp, 8'h00);
         check("R3", rd_data, exp);
      end
      // R3 locked register, every write
      do_reset();
      do_write(8'h58);
      check("R3 first lock write", rd_data, 8'h5A);
      for (int v = 0; v < 256; v++) begin
         do_write(v[7:0]);
         exp = (v[7:0] & 8'h28) | 8'h12;
         check("R3 locked", rd_data, exp);
         sweep_route(exp, "R3 locked");
      end
      // R3 only reset clears lock
      do_reset();
      check("R3 reset clears", rd_data, 8'h02);
      do_write(8'h48);
      check("R3 open after reset", rd_data, 8'h4A);
      // R9 illegal setting specifically
      do_write(8'h68);
      check("R9 stored", rd_data, 8'h6A);
      sweep_route(8'h6A, "R9");
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule